// File: doc/BRIEF.md
# Tiled Crosspoint Array Select Logic

This block steers a larger switch that is built as a grid of `ROWS` by `COLS` eight-port crosspoint tiles. Each tile holds two banks of eight slots: a pending bank written one slot at a time and a live bank that decides which tile input drives each tile output. Every slot is either disabled or a three-bit source index. The caller presents one wide input address, one wide output address, a disable request and three strobes (load, configure, clear). The block splits each address into a tile field and a port field. The output tile field becomes a one-hot row select. The input tile field becomes a set of active-high column disable lines, where at most one line is low. The two port fields are shared by every tile.

All tiles in the selected row act on the same strobe. Only the tile in the column whose disable line is low writes an enabled slot. Every other tile in that row writes a disabled slot for the same output index. In each row the tile outputs with equal index are wire-ORed onto one bus, and the block includes a behavioural model of those buses. That model produces the bused data and flags any output bus that two tiles enable at once.

The control decode is registered, so the tiles act one clock after the caller's request. The bused data is combinational from the live banks and the tile inputs.

Top module: `tiled_xpoint_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `row_cs` is all zero, `col_dis` is all ones, `addr_err`, `in_lo`, `out_lo` and `bus_clash` are zero, and every live slot is disabled, so `data_out` is zero.
- R2: One clock after a request with both addresses in range, `row_cs` has only bit `out_addr[OAW-1:3]` set. In the same clock, `out_lo` equals `out_addr[2:0]` and `in_lo` equals `in_addr[2:0]`.
- R3: One clock after an in-range request without `dis_req`, `col_dis` is all ones except bit `in_addr[IAW-1:3]`, which is zero.
- R4: One clock after a request with `dis_req` high, `col_dis` is all ones, whatever the input address.
- R5: If the input tile field is `COLS` or more, or the output tile field is `ROWS` or more, then one clock later `addr_err` is 1, `row_cs` is zero and `col_dis` is all ones, and no strobe in that request changes any tile.
- R6: A load strobe writes slot `out_lo` of the pending bank of every tile in the selected row. The slot is written enabled with source `in_lo` where that tile's column line is low, and disabled otherwise. `data_out` does not change until a configure strobe.
- R7: A configure strobe copies every pending slot of every tile in the selected row into its live bank. `data_out` then reflects the new live banks from the second clock edge after the request.
- R8: A clear strobe sets both banks of every tile in the selected row. The tile whose column line is low has all eight slots enabled with source 0. All other tiles in that row have all slots disabled. With `dis_req`, every tile in that row is fully disabled.
- R9: A clear strobe takes priority over load and configure in the same request. When load and configure arrive together, the live bank receives the pending contents from before that load.
- R10: Tiles in rows that are not selected keep both banks unchanged.
- R11: `data_out[r*8+k]` is the OR, over the tiles of row r whose live slot k is enabled, of that tile's input bit `data_in[c*8+src]`. It is zero when no tile is enabled. `bus_clash` is 1 exactly when two or more tiles in one row enable the same slot index.
- R12: `data_out` follows changes of `data_in` in the same cycle, with no register in the data path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_addr | input | IAW = clog2(8*COLS) | Wide input address: tile column field above port field |
| out_addr | input | OAW = clog2(8*ROWS) | Wide output address: tile row field above port field |
| dis_req | input | 1 | Request every column disable line high |
| load_stb | input | 1 | Write one pending slot in the selected row |
| cfg_stb | input | 1 | Copy pending bank into live bank for the selected row |
| clr_stb | input | 1 | Set both banks of the selected row to broadcast or disabled |
| data_in | input | 8*COLS | Tile inputs, column c on bits c*8+7..c*8 |
| row_cs | output | ROWS | One-hot tile row select |
| col_dis | output | COLS | Active-high disable line for each tile column |
| in_lo | output | 3 | Shared source port field |
| out_lo | output | 3 | Shared output slot field |
| addr_err | output | 1 | Address outside the array |
| data_out | output | 8*ROWS | Wire-ORed output buses, row r on bits r*8+7..r*8 |
| bus_clash | output | 1 | Two tiles drive one output bus |

## Verification
The bench builds a 3-row by 5-column array instead of the default 4 by 3. With these sizes both tile fields have codes beyond the array (output field 3, input fields 5 to 7), so the range-error path can be driven from either address. Five columns also let the same row be reprogrammed from many columns in turn, which exercises the disabling of the previous owner of an output. A behavioural model of both banks in every tile is compared each clock against all outputs, through directed sequences for strobe collisions and a long random phase.

// File: rtl/xpa_pkg.sv
package xpa_pkg;
    localparam int TILE_PORTS = 8;
    localparam int LO_W       = 3;

    typedef struct packed {
        logic            off;
        logic [LO_W-1:0] src;
    } slot_t;

    localparam slot_t SLOT_OFF = '{off: 1'b1, src: '0};
endpackage

// File: rtl/xpa_decode.sv
module xpa_decode
    import xpa_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 3,
    parameter int IAW  = 5,
    parameter int OAW  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IAW-1:0]   in_addr,
    input  logic [OAW-1:0]   out_addr,
    input  logic             dis_req,
    input  logic             load_stb,
    input  logic             cfg_stb,
    input  logic             clr_stb,
    output logic [ROWS-1:0]  row_cs,
    output logic [COLS-1:0]  col_dis,
    output logic [LO_W-1:0]  in_lo,
    output logic [LO_W-1:0]  out_lo,
    output logic             addr_err,
    output logic             load_q,
    output logic             cfg_q,
    output logic             clr_q
);
    localparam int IHW = IAW - LO_W;
    localparam int OHW = OAW - LO_W;

    typedef struct packed {
        logic [ROWS-1:0] cs;
        logic [COLS-1:0] dis;
        logic [LO_W-1:0] ilo;
        logic [LO_W-1:0] olo;
        logic            err;
        logic            ld;
        logic            cf;
        logic            cl;
    } ctl_t;

    ctl_t           ctl_d, ctl_q;
    logic [IHW-1:0] in_hi;
    logic [OHW-1:0] out_hi;
    logic           in_ok, out_ok, both_ok;

    always_comb begin
        in_hi   = in_addr[IAW-1:LO_W];
        out_hi  = out_addr[OAW-1:LO_W];
        in_ok   = (int'(in_hi) < COLS);
        out_ok  = (int'(out_hi) < ROWS);
        both_ok = in_ok && out_ok;
        ctl_d     = ctl_q;
        ctl_d.err = !both_ok;
        ctl_d.ilo = in_addr[LO_W-1:0];
        ctl_d.olo = out_addr[LO_W-1:0];
        ctl_d.ld  = load_stb;
        ctl_d.cf  = cfg_stb;
        ctl_d.cl  = clr_stb;
        for (int r = 0; r < ROWS; r++) begin
            ctl_d.cs[r] = both_ok && (int'(out_hi) == r);
        end
        for (int c = 0; c < COLS; c++) begin
            ctl_d.dis[c] = !(both_ok && !dis_req && (int'(in_hi) == c));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ctl_q.dis <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign row_cs   = ctl_q.cs;
    assign col_dis  = ctl_q.dis;
    assign in_lo    = ctl_q.ilo;
    assign out_lo   = ctl_q.olo;
    assign addr_err = ctl_q.err;
    assign load_q   = ctl_q.ld;
    assign cfg_q    = ctl_q.cf;
    assign clr_q    = ctl_q.cl;

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_cs)); // R2
    AST_DIS_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        dis_req |=> (col_dis == '1)); // R4
    AST_RANGE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(in_addr[IAW-1:LO_W]) >= COLS) |=> (addr_err && row_cs == '0)); // R5
endmodule

// File: rtl/xpa_tile.sv
module xpa_tile
    import xpa_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel,
    input  logic                  off,
    input  logic [LO_W-1:0]       src_lo,
    input  logic [LO_W-1:0]       dst_lo,
    input  logic                  load,
    input  logic                  cfg,
    input  logic                  clr,
    input  logic [TILE_PORTS-1:0] din,
    output logic [TILE_PORTS-1:0] en_o,
    output logic [TILE_PORTS-1:0] dout
);
    typedef struct packed {
        slot_t [TILE_PORTS-1:0] pend;
        slot_t [TILE_PORTS-1:0] live;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel) begin
            if (clr) begin
                for (int k = 0; k < TILE_PORTS; k++) begin
                    st_d.pend[k] = '{off: off, src: '0};
                    st_d.live[k] = '{off: off, src: '0};
                end
            end else begin
                if (cfg) begin
                    st_d.live = st_q.pend;
                end
                if (load) begin
                    st_d.pend[dst_lo] = '{off: off, src: src_lo};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < TILE_PORTS; k++) begin
                st_q.pend[k] <= SLOT_OFF;
                st_q.live[k] <= SLOT_OFF;
            end
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int k = 0; k < TILE_PORTS; k++) begin
            en_o[k] = !st_q.live[k].off;
            dout[k] = en_o[k] && din[st_q.live[k].src];
        end
    end

    AST_HOLD_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(en_o)); // R10
    AST_CLR_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && clr && !off) |=> (en_o == '1)); // R8
endmodule

// File: rtl/xpa_bus.sv
module xpa_bus
    import xpa_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 3
) (
    input  logic [ROWS*COLS*TILE_PORTS-1:0] tile_en,
    input  logic [ROWS*COLS*TILE_PORTS-1:0] tile_dout,
    output logic [ROWS*TILE_PORTS-1:0]      data_out,
    output logic                            bus_clash
);
    always_comb begin
        data_out  = '0;
        bus_clash = 1'b0;
        for (int r = 0; r < ROWS; r++) begin
            for (int k = 0; k < TILE_PORTS; k++) begin
                int drivers;
                drivers = 0;
                for (int c = 0; c < COLS; c++) begin
                    if (tile_en[(r*COLS+c)*TILE_PORTS+k]) begin
                        drivers = drivers + 1;
                    end
                    data_out[r*TILE_PORTS+k] = data_out[r*TILE_PORTS+k]
                        | tile_dout[(r*COLS+c)*TILE_PORTS+k];
                end
                if (drivers > 1) begin
                    bus_clash = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tiled_xpoint_ctrl.sv
module tiled_xpoint_ctrl
    import xpa_pkg::*;
#(
    parameter  int ROWS = 4,
    parameter  int COLS = 3,
    localparam int IAW  = $clog2(TILE_PORTS*COLS),
    localparam int OAW  = $clog2(TILE_PORTS*ROWS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IAW-1:0]             in_addr,
    input  logic [OAW-1:0]             out_addr,
    input  logic                       dis_req,
    input  logic                       load_stb,
    input  logic                       cfg_stb,
    input  logic                       clr_stb,
    input  logic [TILE_PORTS*COLS-1:0] data_in,
    output logic [ROWS-1:0]            row_cs,
    output logic [COLS-1:0]            col_dis,
    output logic [LO_W-1:0]            in_lo,
    output logic [LO_W-1:0]            out_lo,
    output logic                       addr_err,
    output logic [TILE_PORTS*ROWS-1:0] data_out,
    output logic                       bus_clash
);
    localparam int NTILE = ROWS * COLS;

    logic                          load_q, cfg_q, clr_q;
    logic [NTILE*TILE_PORTS-1:0]   tile_en;
    logic [NTILE*TILE_PORTS-1:0]   tile_dout;

    xpa_decode #(.ROWS(ROWS), .COLS(COLS), .IAW(IAW), .OAW(OAW)) decode_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_addr  (in_addr),
        .out_addr (out_addr),
        .dis_req  (dis_req),
        .load_stb (load_stb),
        .cfg_stb  (cfg_stb),
        .clr_stb  (clr_stb),
        .row_cs   (row_cs),
        .col_dis  (col_dis),
        .in_lo    (in_lo),
        .out_lo   (out_lo),
        .addr_err (addr_err),
        .load_q   (load_q),
        .cfg_q    (cfg_q),
        .clr_q    (clr_q)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            xpa_tile tile_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .sel    (row_cs[r]),
                .off    (col_dis[c]),
                .src_lo (in_lo),
                .dst_lo (out_lo),
                .load   (load_q),
                .cfg    (cfg_q),
                .clr    (clr_q),
                .din    (data_in[c*TILE_PORTS +: TILE_PORTS]),
                .en_o   (tile_en[(r*COLS+c)*TILE_PORTS +: TILE_PORTS]),
                .dout   (tile_dout[(r*COLS+c)*TILE_PORTS +: TILE_PORTS])
            );
        end
    end

    xpa_bus #(.ROWS(ROWS), .COLS(COLS)) bus_i (
        .tile_en   (tile_en),
        .tile_dout (tile_dout),
        .data_out  (data_out),
        .bus_clash (bus_clash)
    );

    AST_COL_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~col_dis) <= 1); // R3
    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_clash); // R11
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> (col_dis == '1)); // R5
endmodule

// File: tb/tiled_xpoint_ctrl_tb_top.sv
module tiled_xpoint_ctrl_tb_top;
    localparam int ROWS = 3;
    localparam int COLS = 5;
    localparam int IAW  = $clog2(8*COLS);
    localparam int OAW  = $clog2(8*ROWS);
    localparam int DIW  = 8*COLS;
    localparam int DOW  = 8*ROWS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [IAW-1:0] in_addr = '0;
    logic [OAW-1:0] out_addr = '0;
    logic dis_req = 1'b0, load_stb = 1'b0, cfg_stb = 1'b0, clr_stb = 1'b0;
    logic [DIW-1:0] data_in = '0;
    logic [ROWS-1:0] row_cs;
    logic [COLS-1:0] col_dis;
    logic [2:0] in_lo, out_lo;
    logic addr_err, bus_clash;
    logic [DOW-1:0] data_out;

    always #10 clk = ~clk;

    tiled_xpoint_ctrl #(.ROWS(ROWS), .COLS(COLS)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_addr(in_addr), .out_addr(out_addr),
        .dis_req(dis_req), .load_stb(load_stb), .cfg_stb(cfg_stb), .clr_stb(clr_stb),
        .data_in(data_in), .row_cs(row_cs), .col_dis(col_dis), .in_lo(in_lo),
        .out_lo(out_lo), .addr_err(addr_err), .data_out(data_out), .bus_clash(bus_clash)
    );

    int n_vec = 0;
    int n_bad = 0;
    string phase = "R1";
    bit running = 1'b0;

    // reference model state
    int p_off [ROWS][COLS][8];
    int p_src [ROWS][COLS][8];
    int a_off [ROWS][COLS][8];
    int a_src [ROWS][COLS][8];
    logic [ROWS-1:0] e_cs;
    logic [COLS-1:0] e_dis;
    int e_ilo, e_olo;
    bit e_err, e_ld, e_cf, e_cl, e_dq;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++)
                    for (int k = 0; k < 8; k++) begin
                        p_off[r][c][k] = 1; p_src[r][c][k] = 0;
                        a_off[r][c][k] = 1; a_src[r][c][k] = 0;
                    end
            e_cs = '0; e_dis = '1; e_ilo = 0; e_olo = 0;
            e_err = 0; e_ld = 0; e_cf = 0; e_cl = 0; e_dq = 0;
        end else begin
            int iu, ou;
            bit ok;
            for (int r = 0; r < ROWS; r++) begin
                if (e_cs[r]) begin
                    for (int c = 0; c < COLS; c++) begin
                        int o;
                        o = e_dis[c] ? 1 : 0;
                        if (e_cl) begin
                            for (int k = 0; k < 8; k++) begin
                                p_off[r][c][k] = o; p_src[r][c][k] = 0;
                                a_off[r][c][k] = o; a_src[r][c][k] = 0;
                            end
                        end else begin
                            if (e_cf)
                                for (int k = 0; k < 8; k++) begin
                                    a_off[r][c][k] = p_off[r][c][k];
                                    a_src[r][c][k] = p_src[r][c][k];
                                end
                            if (e_ld) begin
                                p_off[r][c][e_olo] = o;
                                p_src[r][c][e_olo] = e_ilo;
                            end
                        end
                    end
                end
            end
            iu = int'(in_addr) / 8;
            ou = int'(out_addr) / 8;
            ok = (iu < COLS) && (ou < ROWS);
            e_cs = '0;
            if (ok) e_cs[ou] = 1'b1;
            e_dis = '1;
            if (ok && !dis_req) e_dis[iu] = 1'b0;
            e_err = !ok;
            e_ilo = int'(in_addr) % 8;
            e_olo = int'(out_addr) % 8;
            e_ld = load_stb; e_cf = cfg_stb; e_cl = clr_stb; e_dq = dis_req;
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (running && rst_n) begin
            logic [DOW-1:0] e_do;
            bit e_clash;
            e_do = '0;
            e_clash = 0;
            for (int r = 0; r < ROWS; r++)
                for (int k = 0; k < 8; k++) begin
                    int n;
                    n = 0;
                    for (int c = 0; c < COLS; c++)
                        if (a_off[r][c][k] == 0) begin
                            n++;
                            if (data_in[c*8 + a_src[r][c][k]]) e_do[r*8+k] = 1'b1;
                        end
                    if (n > 1) e_clash = 1;
                end
            chk("R2 row_cs", 64'(row_cs), 64'(e_cs));
            chk("R2 in_lo", 64'(in_lo), 64'(e_ilo));
            chk("R2 out_lo", 64'(out_lo), 64'(e_olo));
            chk(e_dq ? "R4 col_dis" : "R3 col_dis", 64'(col_dis), 64'(e_dis));
            chk("R5 addr_err", 64'(addr_err), 64'(e_err));
            chk({phase, " data_out"}, 64'(data_out), 64'(e_do));
            chk("R11 bus_clash", 64'(bus_clash), 64'(e_clash));
        end
    end

    task automatic drive(int ia, int oa, bit dq, bit ld, bit cf, bit cl);
        logic [63:0] r64;
        @(posedge clk);
        #2;
        r64 = {$urandom(), $urandom()};
        in_addr = IAW'(ia);
        out_addr = OAW'(oa);
        dis_req = dq; load_stb = ld; cfg_stb = cf; clr_stb = cl;
        data_in = r64[DIW-1:0];
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 row_cs", 64'(row_cs), 64'd0);
        chk("R1 col_dis", 64'(col_dis), 64'((1 << COLS) - 1));
        chk("R1 addr_err", 64'(addr_err), 64'd0);
        chk("R1 data_out", 64'(data_out), 64'd0);
        chk("R1 bus_clash", 64'(bus_clash), 64'd0);
        running = 1'b1;

        phase = "R6";
        for (int k = 0; k < 8; k++) drive(2*8 + (7-k), 1*8 + k, 0, 1, 0, 0);
        idle(3);

        phase = "R7";
        drive(2*8, 1*8, 0, 0, 1, 0);
        idle(3);

        phase = "R12";
        idle(6);

        phase = "R8";
        drive(4*8, 2*8, 0, 0, 0, 1);
        idle(3);
        drive(1*8, 2*8, 1, 0, 0, 1);
        idle(2);
        drive(3*8, 2*8 + 5, 0, 0, 0, 1);
        idle(2);

        phase = "R9";
        drive(1*8 + 5, 0*8 + 3, 0, 1, 1, 0);
        idle(2);
        drive(0, 0, 0, 0, 1, 0);
        idle(2);
        drive(0*8 + 6, 0*8 + 3, 0, 1, 0, 1);
        idle(2);
        drive(0, 0, 0, 0, 1, 0);
        idle(2);

        phase = "R10";
        drive(3*8 + 2, 1*8 + 4, 0, 1, 0, 0);
        drive(0, 0, 0, 0, 1, 0);
        idle(2);
        drive(3*8, 1*8, 0, 0, 1, 0);
        idle(2);

        phase = "R5";
        drive(6*8 + 1, 1*8 + 2, 0, 1, 1, 0);
        idle(1);
        drive(7*8, 1*8, 0, 0, 0, 1);
        idle(1);
        drive(1*8 + 2, 3*8 + 1, 0, 1, 1, 1);
        idle(2);

        phase = "R4";
        drive(2*8 + 3, 1*8 + 0, 1, 1, 0, 0);
        drive(2*8, 1*8, 1, 0, 1, 0);
        idle(2);

        phase = "R11";
        for (int i = 0; i < 800; i++) begin
            int pick;
            pick = $urandom_range(0, 9);
            drive($urandom_range(0, 63), $urandom_range(0, 31),
                  ($urandom_range(0, 7) == 0),
                  pick < 5, pick == 5 || pick == 6 || pick == 9, pick == 7);
        end
        idle(3);
        finish_run();
    end
endmodule